// File: doc/BRIEF.md
# Interrupt Routing Controller Register Window

This block holds the configuration state of an I/O interrupt routing controller and makes it reachable from a processor bus through only two 32-bit locations. The first location is an index register. The second is a data window that reads or writes whichever internal register the index currently names. The routing logic does not use the bus. It takes every programmed redirection entry as a wide parallel output.

The internal registers are as follows. A controller identifier and an arbitration identifier each sit in the top byte of their word. A read-only word reports the version code and the highest entry number. The table holds 64-bit redirection entries, and each entry is split into a low half and a high half at two neighbouring indices. Each entry carries these fields: vector in bits 7:0, delivery mode in 10:8, destination mode in bit 11, polarity in bit 13, trigger mode in bit 15, mask in bit 16 and destination in 63:56. Software programs an entry by writing the index and then the window, once for each half. A write always forces that half's unused bits to zero.

Top module: `irq_route_regfile`

## Requirements
- R1: An access is legal only with byte enables 4'hF at byte offset 0x00 or 0x10. Any other access changes no state. It raises `acc_err` for exactly the following cycle. If it is a read, it returns `rd_data` 0.
- R2: Every read, legal or not, gives `rd_valid` high with its data on the cycle after it is presented. A write never raises `rd_valid`.
- R3: A write at offset 0x00 loads `bus_wdata[7:0]` into the 8-bit index. A read at offset 0x00 returns the index zero-extended. The index resets to 0.
- R4: Index 0x00 holds the controller identifier. A write stores `bus_wdata[31:24]`. A read returns the identifier in bits 31:24 with all other bits 0. It resets to `INIT_ID` (default 0x05).
- R5: Index 0x01 reads as 0x00170011 with default parameters: entry count minus one in bits 23:16 and version 0x11 in bits 7:0. Writes to it have no effect.
- R6: Index 0x02 holds the arbitration identifier. It is stored from and returned in bits 31:24, and it resets to `INIT_ID`.
- R7: Entry n has its low half at index 0x10+2n and its high half at 0x11+2n. It appears on `route_entries[n*64 +: 64]` as {high, low}.
- R8: A write to a low half keeps only the bits under mask 0x0001AFFF. A write to a high half keeps only the bits under mask 0xFF000000. All other bits of that half become 0.
- R9: After reset every entry has low half 0x00010000 (mask bit 16 set) and high half 0.
- R10: An undefined index reads as 0, and a write to it has no effect. The undefined indices are 0x03 to 0x0F and 0x10+2*entries up to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; only 4'hF is legal |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | One-cycle pulse after an illegal access |
| route_entries | output | NUM_ENTRIES*64 | All redirection entries, entry n at bits n*64 +: 64 |

## Verification
A bad index shows up on the first window access after it: the read returns another register's value, or a write lands in the wrong entry, and both are visible on `route_entries` one cycle later. Faulty reserved-bit or reset handling shows on `route_entries` immediately. A decode fault shows on `acc_err` or `rd_valid` in the cycle after the offending access. A lost write is caught only when its register is next read back.

// File: rtl/irq_route_pkg.sv
// Shared constants and types for the interrupt routing register window.
// Assumes an 8-bit internal index space.
package irq_route_pkg;
    localparam int IDX_W = 8;

    localparam logic [IDX_W-1:0] IDX_ID  = 8'h00;
    localparam logic [IDX_W-1:0] IDX_VER = 8'h01;
    localparam logic [IDX_W-1:0] IDX_ARB = 8'h02;
    localparam logic [IDX_W-1:0] IDX_TBL = 8'h10;

    // Bits kept on a write to each half of an entry
    localparam logic [31:0] LO_KEEP  = 32'h0001_AFFF;
    localparam logic [31:0] HI_KEEP  = 32'hFF00_0000;
    localparam logic [31:0] LO_RESET = 32'h0001_0000;
    localparam logic [31:0] HI_RESET = 32'h0000_0000;

    typedef struct packed {
        logic sel_wr;
        logic sel_rd;
        logic win_wr;
        logic win_rd;
        logic bad;
    } bus_acc_t;
endpackage

// File: rtl/irq_bus_decode.sv
// Classifies one bus access as index access, window access or illegal.
// Assumes a single access per cycle, qualified by valid.
module irq_bus_decode
    import irq_route_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int SEL_OFS = 0,
    parameter int WIN_OFS = 16
) (
    input  logic              valid,
    input  logic              write,
    input  logic [3:0]        be,
    input  logic [ADDR_W-1:0] addr,
    output bus_acc_t          acc
);
    localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(SEL_OFS);
    localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(WIN_OFS);

    logic full_word;
    logic hit_sel;
    logic hit_win;

    // Decode offset and size into access kinds
    always_comb begin
        full_word  = (be == 4'hF);
        hit_sel    = full_word && (addr == SEL_A);
        hit_win    = full_word && (addr == WIN_A);
        acc.sel_wr = valid && write  && hit_sel;
        acc.sel_rd = valid && !write && hit_sel;
        acc.win_wr = valid && write  && hit_win;
        acc.win_rd = valid && !write && hit_win;
        acc.bad    = valid && !(hit_sel || hit_win);
    end
endmodule

// File: rtl/irq_entry_store.sv
// Holds the redirection table: one low and one high 32-bit half per entry.
// Clears unused bits on write. Assumes 0x10 + 2*NUM_ENTRIES <= 256.
module irq_entry_store
    import irq_route_pkg::*;
#(
    parameter int NUM_ENTRIES = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         idx,
    input  logic [31:0]              wdata,
    output logic [NUM_ENTRIES*64-1:0] entries
);
    for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_ent
        localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(int'(IDX_TBL) + 2 * n);
        localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(int'(IDX_TBL) + 2 * n + 1);

        logic [31:0] lo_q;
        logic [31:0] hi_q;

        // Update one entry's halves when the index names them
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= LO_RESET;
                hi_q <= HI_RESET;
            end else if (wr_en) begin
                if (idx == LO_IDX) lo_q <= wdata & LO_KEEP;
                if (idx == HI_IDX) hi_q <= wdata & HI_KEEP;
            end
        end

        assign entries[n*64 +: 64] = {hi_q, lo_q};
    end
endmodule

// File: rtl/irq_window_mux.sv
// Selects the 32-bit value seen through the data window for a given index.
// Purely combinational; undefined indices yield zero.
module irq_window_mux
    import irq_route_pkg::*;
#(
    parameter int          NUM_ENTRIES = 24,
    parameter logic [7:0]  VERSION     = 8'h11
) (
    input  logic [IDX_W-1:0]          idx,
    input  logic [7:0]                id_val,
    input  logic [7:0]                arb_val,
    input  logic [NUM_ENTRIES*64-1:0] entries,
    output logic [31:0]               rdata
);
    localparam int          TBL_END  = int'(IDX_TBL) + 2 * NUM_ENTRIES;
    localparam logic [7:0]  LAST_ENT = 8'(NUM_ENTRIES - 1);

    logic [IDX_W-1:0] rel;
    logic             in_tbl;

    // Locate the table half addressed by the index
    always_comb begin
        rel    = idx - IDX_TBL;
        in_tbl = (idx >= IDX_TBL) && ({1'b0, idx} < (IDX_W+1)'(TBL_END));
    end

    // Choose the word returned by a window read
    always_comb begin
        rdata = 32'h0;
        if (idx == IDX_ID)       rdata = {id_val, 24'h0};
        else if (idx == IDX_VER) rdata = {8'h00, LAST_ENT, 8'h00, VERSION};
        else if (idx == IDX_ARB) rdata = {arb_val, 24'h0};
        else if (in_tbl)         rdata = entries[int'(rel)*32 +: 32];
    end
endmodule

// File: rtl/irq_route_regfile.sv
// Indirect register file for an interrupt routing controller: index at
// offset 0x00, data window at 0x10, one-cycle read latency, error pulse
// on illegal access. Assumes INIT_ID < 8'hFF (0xFF is reserved downstream).
module irq_route_regfile
    import irq_route_pkg::*;
#(
    parameter int         NUM_ENTRIES = 24,
    parameter int         ADDR_W      = 8,
    parameter logic [7:0] INIT_ID     = 8'h05,
    parameter logic [7:0] VERSION     = 8'h11
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [3:0]                bus_be,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic                      rd_valid,
    output logic [31:0]               rd_data,
    output logic                      acc_err,
    output logic [NUM_ENTRIES*64-1:0] route_entries
);
    bus_acc_t         acc;
    logic [IDX_W-1:0] sel_q;
    logic [7:0]       id_q;
    logic [7:0]       arb_q;
    logic [31:0]      win_rdata;

    irq_bus_decode #(
        .ADDR_W (ADDR_W),
        .SEL_OFS(0),
        .WIN_OFS(16)
    ) u_dec (
        .valid(bus_valid),
        .write(bus_write),
        .be   (bus_be),
        .addr (bus_addr),
        .acc  (acc)
    );

    irq_entry_store #(
        .NUM_ENTRIES(NUM_ENTRIES)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (acc.win_wr),
        .idx    (sel_q),
        .wdata  (bus_wdata),
        .entries(route_entries)
    );

    irq_window_mux #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .VERSION    (VERSION)
    ) u_mux (
        .idx    (sel_q),
        .id_val (id_q),
        .arb_val(arb_q),
        .entries(route_entries),
        .rdata  (win_rdata)
    );

    // Index register and the two identifier registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            id_q  <= INIT_ID;
            arb_q <= INIT_ID;
        end else begin
            if (acc.sel_wr) sel_q <= bus_wdata[IDX_W-1:0];
            if (acc.win_wr && sel_q == IDX_ID)  id_q  <= bus_wdata[31:24];
            if (acc.win_wr && sel_q == IDX_ARB) arb_q <= bus_wdata[31:24];
        end
    end

    // Registered read response and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= 32'h0;
            acc_err  <= 1'b0;
        end else begin
            rd_valid <= bus_valid && !bus_write;
            acc_err  <= acc.bad;
            if (acc.sel_rd)      rd_data <= {{(32-IDX_W){1'b0}}, sel_q};
            else if (acc.win_rd) rd_data <= win_rdata;
            else                 rd_data <= 32'h0;
        end
    end
endmodule

// File: rtl/irq_route_regfile_chk.sv
// Port-level temporal checks for irq_route_regfile, bound to every instance.
module irq_route_regfile_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_ENTRIES = 24,
    parameter int ADDR_W      = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_valid,
    input logic                      bus_write,
    input logic [3:0]                bus_be,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      rd_valid,
    input logic [31:0]               rd_data,
    input logic                      acc_err,
    input logic [NUM_ENTRIES*64-1:0] route_entries
);
    logic illegal;
    assign illegal = bus_valid && (bus_be != 4'hF ||
                     (bus_addr != ADDR_W'(0) && bus_addr != ADDR_W'(16)));

    assert_err_cause_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(illegal));

    assert_err_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> acc_err);

    assert_bad_keeps_table_R1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> $stable(route_entries));

    assert_bad_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && acc_err) |-> (rd_data == 32'h0));

    assert_rd_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> rd_valid);

    assert_rd_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_valid && !bus_write));

    for (genvar n = 0; n < NUM_ENTRIES; n++) begin : g_rsv
        assert_lo_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (route_entries[n*64 +: 32] & ~LO_KEEP) == 32'h0);
        assert_hi_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (route_entries[n*64+32 +: 32] & ~HI_KEEP) == 32'h0);
    end
endmodule

bind irq_route_regfile irq_route_regfile_chk #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_valid    (bus_valid),
    .bus_write    (bus_write),
    .bus_be       (bus_be),
    .bus_addr     (bus_addr),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .acc_err      (acc_err),
    .route_entries(route_entries)
);

// File: tb/sim_irq_route_regfile.sv
module sim_irq_route_regfile;
    localparam int NE = 24;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_valid = 1'b0;
    logic            bus_write = 1'b0;
    logic [3:0]      bus_be = 4'h0;
    logic [7:0]      bus_addr = 8'h0;
    logic [31:0]     bus_wdata = 32'h0;
    logic            rd_valid;
    logic [31:0]     rd_data;
    logic            acc_err;
    logic [NE*64-1:0] route_entries;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic        cap_valid;
    logic [31:0] cap_data;
    logic        cap_err;

    always #5 clk = ~clk;

    irq_route_regfile #(.NUM_ENTRIES(NE)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_be(bus_be), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
        .route_entries(route_entries)
    );

    typedef struct packed {
        logic        rd;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 32'h0000_0000, 8'd3},
        '{1'b1, 8'h10, 32'h0500_0000, 8'd4},   // R4 reset identifier
        '{1'b0, 8'h10, 32'hAB12_3456, 8'd4},
        '{1'b1, 8'h10, 32'hAB00_0000, 8'd4},   // R4 only top byte kept
        '{1'b0, 8'h00, 32'h0000_0001, 8'd3},
        '{1'b0, 8'h10, 32'hFFFF_FFFF, 8'd5},
        '{1'b1, 8'h10, 32'h0017_0011, 8'd5},   // R5 version, write ignored
        '{1'b0, 8'h00, 32'h0000_0002, 8'd3},
        '{1'b1, 8'h10, 32'h0500_0000, 8'd6},   // R6 reset arbitration id
        '{1'b0, 8'h10, 32'h7F00_00FF, 8'd6},
        '{1'b1, 8'h10, 32'h7F00_0000, 8'd6},   // R6
        '{1'b0, 8'h00, 32'h0000_0010, 8'd3},
        '{1'b1, 8'h10, 32'h0001_0000, 8'd9},   // R9 entry 0 low at reset
        '{1'b0, 8'h10, 32'hFFFF_FFFF, 8'd8},
        '{1'b1, 8'h10, 32'h0001_AFFF, 8'd8},   // R8 low keep mask
        '{1'b0, 8'h00, 32'h0000_0011, 8'd3},
        '{1'b0, 8'h10, 32'hFFFF_FFFF, 8'd8},
        '{1'b1, 8'h10, 32'hFF00_0000, 8'd8},   // R8 high keep mask
        '{1'b0, 8'h00, 32'h0000_003F, 8'd7},
        '{1'b0, 8'h10, 32'h1234_5678, 8'd7},
        '{1'b1, 8'h10, 32'h1200_0000, 8'd7},   // R7 last entry high half
        '{1'b0, 8'h00, 32'h0000_0040, 8'd10},
        '{1'b0, 8'h10, 32'hFFFF_FFFF, 8'd10},
        '{1'b1, 8'h10, 32'h0000_0000, 8'd10},  // R10 past the table
        '{1'b1, 8'h00, 32'h0000_0040, 8'd3}    // R3 index readback
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] addr,
                          input logic [31:0] data, input logic [3:0] be);
        @(negedge clk);
        bus_valid = 1'b1;
        bus_write = wr;
        bus_addr  = addr;
        bus_wdata = data;
        bus_be    = be;
        @(posedge clk);
        #1;
        cap_valid = rd_valid;
        cap_data  = rd_data;
        cap_err   = acc_err;
        bus_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        finish_run();
    end

    initial begin
        logic [NE*64-1:0] snap;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R9 reset state of every entry and of the response outputs
        chk("R2 rd_valid at reset", 64'(rd_valid), 64'd0);
        chk("R1 acc_err at reset", 64'(acc_err), 64'd0);
        begin
            int bad = 0;
            for (int n = 0; n < NE; n++)
                if (route_entries[n*64 +: 64] !== 64'h0000_0000_0001_0000) bad++;
            chk("R9 entries at reset", 64'(bad), 64'd0);
        end
        access(1'b0, 8'h00, 32'h0, 4'hF);
        chk("R3 index reset value", 64'(cap_data), 64'd0);
        chk("R2 read gives rd_valid", 64'(cap_valid), 64'd1);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            access(!VEC[i].rd, VEC[i].addr, VEC[i].rd ? 32'h0 : VEC[i].data, 4'hF);
            if (VEC[i].rd)
                chk($sformatf("R%0d vector %0d", VEC[i].req, i), 64'(cap_data), 64'(VEC[i].data));
            else
                chk($sformatf("R2 no rd_valid on write, vector %0d", i), 64'(cap_valid), 64'd0);
        end

        // R7 parallel output layout
        chk("R7 entry 0 on output", route_entries[0 +: 64], 64'hFF00_0000_0001_AFFF);
        chk("R7 entry 23 on output", route_entries[23*64 +: 64], 64'h1200_0000_0001_0000);

        // R1 illegal read offset
        access(1'b0, 8'h04, 32'h0, 4'hF);
        chk("R1 illegal read err", 64'(cap_err), 64'd1);
        chk("R1 illegal read data", 64'(cap_data), 64'd0);
        chk("R2 illegal read still valid", 64'(cap_valid), 64'd1);
        @(posedge clk); #1;
        chk("R1 err lasts one cycle", 64'(acc_err), 64'd0);

        // R1 partial-width write to window leaves entry 0 low untouched
        access(1'b1, 8'h00, 32'h0000_0010, 4'hF);
        chk("R1 legal access no err", 64'(cap_err), 64'd0);
        snap = route_entries;
        access(1'b1, 8'h10, 32'h0000_0000, 4'h3);
        chk("R1 partial write err", 64'(cap_err), 64'd1);
        access(1'b1, 8'h14, 32'h0000_0000, 4'hF);
        chk("R1 bad offset write err", 64'(cap_err), 64'd1);
        chk("R1 table unchanged", 64'(route_entries == snap), 64'd1);
        access(1'b0, 8'h10, 32'h0, 4'hF);
        chk("R1 entry 0 low kept", 64'(cap_data), 64'h0001_AFFF);
        access(1'b0, 8'h00, 32'h0, 4'hF);
        chk("R1 index kept after bad write", 64'(cap_data), 64'h10);

        // R10 undefined index in gap below table
        access(1'b1, 8'h00, 32'h0000_000F, 4'hF);
        access(1'b1, 8'h10, 32'hFFFF_FFFF, 4'hF);
        chk("R10 gap write no effect", 64'(route_entries == snap), 64'd1);
        access(1'b0, 8'h10, 32'h0, 4'hF);
        chk("R10 gap read zero", 64'(cap_data), 64'd0);

        // R8 entry 5 low, arbitrary pattern
        access(1'b1, 8'h00, 32'h0000_001A, 4'hF);
        access(1'b1, 8'h10, 32'h5A5A_5A5A, 4'hF);
        chk("R8 entry 5 low masked", route_entries[5*64 +: 64], 64'h0000_0000_0000_0A5A);

        // R9 R4 reset reapplied mid-run
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R9 entry 0 after reset", route_entries[0 +: 64], 64'h0000_0000_0001_0000);
        access(1'b0, 8'h10, 32'h0, 4'hF);
        chk("R4 id after re-reset", 64'(cap_data), 64'h0500_0000);

        finish_run();
    end
endmodule